// File: doc/BRIEF.md
# Wavefront Issue Scheduler

This block chooses the next wavefront to issue in a compute unit built from four 16-lane vector SIMD units. Every wavefront is a 64-thread group held in a resident slot of the SIMD it was given at allocation, and it stays on that SIMD until it is freed. Each slot keeps a valid flag, a memory-wait flag and its own program counter.

The scheduler visits one SIMD per clock in a fixed rotation 0, 1, 2, 3. On its turn a SIMD picks a ready wavefront in round-robin order and streams it over four consecutive cycles as lane groups 0 to 3, 16 threads per cycle. Because the rotation has four steps, the SIMD comes round again in the cycle its last lane group runs, so an issue can follow directly. A slot stalled on memory is passed over and the SIMD runs another resident wavefront instead. Surrounding logic allocates and frees slots, marks a slot as waiting when it starts a memory access, and wakes it when the data returns.

Top module: `wave_issue_sched`

## Requirements
- R1: After reset no slot is valid, `issue_valid` and every bit of `lane_active` are 0, and an allocation request to any SIMD returns slot 0 without `alloc_full`.
- R2: The rising edge numbered k after reset release (k = 1, 2, ...) serves SIMD (k-1) mod 4; the issue result of that edge is on `issue_valid`, `issue_simd`, `issue_slot` and `issue_pc` in the following cycle, with `issue_simd` equal to the served SIMD.
- R3: After an issue on SIMD s, `lane_active[s]` is 1 for the next four cycles, and `lane_group[2s+1:2s]` reads 0, 1, 2, 3 in those cycles.
- R4: An allocation request returns, in the same cycle, the lowest-numbered free slot of the named SIMD; with all 10 slots of that SIMD valid it raises `alloc_full` and changes no state.
- R5: On its turn a SIMD chooses the first ready slot after the slot it last issued, wrapping from 9 to 0; after reset the search starts at slot 0.
- R6: A slot is ready when valid and not waiting; a waiting slot is skipped, and a SIMD with no ready slot sets `issue_valid` to 0 for that turn and leaves `lane_active[s]` at 0 for the next four cycles.
- R7: `stall_req` marks a slot waiting and `wake_req` clears the mark; a wake accepted at the same edge as that SIMD's turn does not make the slot eligible at that edge, only at later turns. If stall and wake name the same slot at one edge, the wake wins.
- R8: `free_req` clears a slot; a freed slot is no longer issued and is the first candidate for the next allocation to its SIMD.
- R9: `issue_pc` shows the slot's program counter before the issue; the counter starts at `alloc_pc` and grows by PC_STEP (4) after each issue of that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Request a new wavefront slot |
| alloc_simd | input | 2 | SIMD that receives the new wavefront |
| alloc_pc | input | 48 | Start program counter of the new wavefront |
| alloc_slot | output | 4 | Slot granted to the request (same cycle) |
| alloc_full | output | 1 | Request rejected, SIMD has no free slot |
| free_req | input | 1 | Release a slot |
| free_simd | input | 2 | SIMD of the released slot |
| free_slot | input | 4 | Released slot |
| stall_req | input | 1 | Mark a slot as waiting on memory |
| stall_simd | input | 2 | SIMD of the stalled slot |
| stall_slot | input | 4 | Stalled slot |
| wake_req | input | 1 | Memory result returned for a slot |
| wake_simd | input | 2 | SIMD of the woken slot |
| wake_slot | input | 4 | Woken slot |
| issue_valid | output | 1 | A wavefront was issued at the last edge |
| issue_simd | output | 2 | SIMD served at the last edge |
| issue_slot | output | 4 | Slot issued |
| issue_pc | output | 48 | Program counter of the issued wavefront |
| lane_active | output | 4 | Per SIMD: a wavefront is streaming this cycle |
| lane_group | output | 8 | Per SIMD: 2-bit lane group index streaming now |

## Verification
The assertions assume that free, stall and wake requests only name slots that hold a wavefront, and that slot and SIMD indices stay below 10 and 4. An allocated slot is expected to become valid at the edge that grants it, which only holds while no free request names the same slot at that edge; the stimulus frees only slots it allocated earlier and never frees and allocates in one cycle. Stall and wake requests in the bench are spaced out so that each lands on a known turn of the rotation, which lets the expected slot of every issue follow from the round-robin rule alone.

// File: rtl/wave_issue_sched.sv
module wave_issue_sched #(
  parameter int NUM_SIMD     = 4,
  parameter int SLOTS        = 10,
  parameter int PC_W         = 48,
  parameter int PC_STEP      = 4,
  parameter int WAVE_THREADS = 64,
  parameter int LANES        = 16,
  localparam int GROUPS      = WAVE_THREADS / LANES,
  localparam int SW          = $clog2(NUM_SIMD),
  localparam int SLW         = $clog2(SLOTS),
  localparam int GW          = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_req,
  input  logic [SW-1:0]          alloc_simd,
  input  logic [PC_W-1:0]        alloc_pc,
  output logic [SLW-1:0]         alloc_slot,
  output logic                   alloc_full,
  input  logic                   free_req,
  input  logic [SW-1:0]          free_simd,
  input  logic [SLW-1:0]         free_slot,
  input  logic                   stall_req,
  input  logic [SW-1:0]          stall_simd,
  input  logic [SLW-1:0]         stall_slot,
  input  logic                   wake_req,
  input  logic [SW-1:0]          wake_simd,
  input  logic [SLW-1:0]         wake_slot,
  output logic                   issue_valid,
  output logic [SW-1:0]          issue_simd,
  output logic [SLW-1:0]         issue_slot,
  output logic [PC_W-1:0]        issue_pc,
  output logic [NUM_SIMD-1:0]    lane_active,
  output logic [NUM_SIMD*GW-1:0] lane_group
);

  logic [NUM_SIMD-1:0][SLOTS-1:0] vld, wt;
  logic [PC_W-1:0]                pc   [NUM_SIMD][SLOTS];
  logic [SLW-1:0]                 last [NUM_SIMD];
  logic [SW-1:0]                  turn;
  logic [NUM_SIMD-1:0]            act;
  logic [NUM_SIMD-1:0][GW-1:0]    grp;

  logic                           free_found;
  logic [SLOTS-1:0]               elig;
  logic                           pick_ok;
  logic [SLW-1:0]                 pick;
  logic                           grant;

  always_comb begin
    alloc_slot = '0;
    free_found = 1'b0;
    for (int i = 0; i < SLOTS; i++)
      if (!free_found && !vld[alloc_simd][i]) begin
        alloc_slot = SLW'(i);
        free_found = 1'b1;
      end
  end

  assign alloc_full = alloc_req & ~free_found;
  assign grant      = alloc_req & free_found;
  assign elig       = vld[turn] & ~wt[turn];

  always_comb begin
    int idx;
    idx     = 0;
    pick    = '0;
    pick_ok = 1'b0;
    for (int k = 1; k <= SLOTS; k++) begin
      idx = int'(last[turn]) + k;
      if (idx >= SLOTS) idx = idx - SLOTS;
      if (!pick_ok && elig[idx]) begin
        pick    = SLW'(idx);
        pick_ok = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld         <= '0;
      wt          <= '0;
      turn        <= '0;
      act         <= '0;
      grp         <= '0;
      issue_valid <= 1'b0;
      issue_simd  <= '0;
      issue_slot  <= '0;
      issue_pc    <= '0;
      for (int s = 0; s < NUM_SIMD; s++) last[s] <= SLW'(SLOTS - 1);
    end else begin
      turn <= (turn == SW'(NUM_SIMD - 1)) ? '0 : SW'(turn + 1'b1);
      if (grant) begin
        vld[alloc_simd][alloc_slot] <= 1'b1;
        wt[alloc_simd][alloc_slot]  <= 1'b0;
      end
      if (stall_req) wt[stall_simd][stall_slot] <= 1'b1;
      if (wake_req)  wt[wake_simd][wake_slot]   <= 1'b0;
      if (free_req) begin
        vld[free_simd][free_slot] <= 1'b0;
        wt[free_simd][free_slot]  <= 1'b0;
      end
      issue_valid <= pick_ok;
      issue_simd  <= turn;
      issue_slot  <= pick;
      issue_pc    <= pc[turn][pick];
      if (pick_ok) last[turn] <= pick;
      for (int s = 0; s < NUM_SIMD; s++) begin
        if (SW'(s) == turn) begin
          act[s] <= pick_ok;
          grp[s] <= '0;
        end else if (act[s]) begin
          grp[s] <= GW'(grp[s] + 1'b1);
          if (grp[s] == GW'(GROUPS - 1)) act[s] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (grant) pc[alloc_simd][alloc_slot] <= alloc_pc;
    if (rst_n && pick_ok) pc[turn][pick] <= pc[turn][pick] + PC_W'(PC_STEP);
  end

  assign lane_active = act;
  assign lane_group  = grp;

endmodule

// File: rtl/wave_issue_sched_chk.sv
module wave_issue_sched_chk #(
  parameter int NUM_SIMD = 4,
  parameter int SLOTS    = 10,
  parameter int GW       = 2,
  localparam int SW      = $clog2(NUM_SIMD),
  localparam int SLW     = $clog2(SLOTS)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           alloc_req,
  input logic [SW-1:0]                  alloc_simd,
  input logic [SLW-1:0]                 alloc_slot,
  input logic                           alloc_full,
  input logic                           issue_valid,
  input logic [SW-1:0]                  issue_simd,
  input logic [SLW-1:0]                 issue_slot,
  input logic [NUM_SIMD-1:0]            lane_active,
  input logic [NUM_SIMD*GW-1:0]         lane_group,
  input logic [NUM_SIMD-1:0][SLOTS-1:0] vld,
  input logic [NUM_SIMD-1:0][SLOTS-1:0] wt
);

  logic [SW-1:0]                  chk_turn;
  logic [NUM_SIMD-1:0][SLOTS-1:0] vld_q, wt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_turn <= '0;
      vld_q    <= '0;
      wt_q     <= '0;
    end else begin
      chk_turn <= SW'((int'(chk_turn) + 1) % NUM_SIMD);
      vld_q    <= vld;
      wt_q     <= wt;
    end
  end

  AST_TURN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> issue_simd == SW'((int'(chk_turn) + NUM_SIMD - 1) % NUM_SIMD)); // R2

  AST_ISSUE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> vld_q[issue_simd][issue_slot] && !wt_q[issue_simd][issue_slot]); // R6

  AST_ALLOC_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !alloc_full) |=> vld[$past(alloc_simd)][$past(alloc_slot)]); // R4

  AST_FULL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_full) |-> (&vld[alloc_simd])); // R4

  for (genvar s = 0; s < NUM_SIMD; s++) begin : g_lane
    AST_LANE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_active[s] && lane_group[s*GW +: GW] == '0) |-> (issue_valid && issue_simd == SW'(s))); // R3
    AST_LANE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_active[s] && lane_group[s*GW +: GW] != '0) |->
        ($past(lane_active[s]) && lane_group[s*GW +: GW] == GW'($past(lane_group[s*GW +: GW]) + 1'b1))); // R3
  end

endmodule

bind wave_issue_sched wave_issue_sched_chk #(
  .NUM_SIMD(NUM_SIMD), .SLOTS(SLOTS), .GW(GW)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .alloc_req(alloc_req), .alloc_simd(alloc_simd), .alloc_slot(alloc_slot), .alloc_full(alloc_full),
  .issue_valid(issue_valid), .issue_simd(issue_simd), .issue_slot(issue_slot),
  .lane_active(lane_active), .lane_group(lane_group),
  .vld(vld), .wt(wt)
);

// File: tb/wave_issue_sched_tb.sv
`timescale 1ns/1ps
module wave_issue_sched_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_req = 1'b0;
  logic [1:0]  alloc_simd = '0;
  logic [47:0] alloc_pc = '0;
  logic [3:0]  alloc_slot;
  logic        alloc_full;
  logic        free_req = 1'b0;
  logic [1:0]  free_simd = '0;
  logic [3:0]  free_slot = '0;
  logic        stall_req = 1'b0;
  logic [1:0]  stall_simd = '0;
  logic [3:0]  stall_slot = '0;
  logic        wake_req = 1'b0;
  logic [1:0]  wake_simd = '0;
  logic [3:0]  wake_slot = '0;
  logic        issue_valid;
  logic [1:0]  issue_simd;
  logic [3:0]  issue_slot;
  logic [47:0] issue_pc;
  logic [3:0]  lane_active;
  logic [7:0]  lane_group;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  localparam logic [47:0] P0 = 48'h0000_1000;
  localparam logic [47:0] P1 = 48'h0000_2040;
  localparam logic [47:0] P2 = 48'h0000_3300;

  // {simd[1:0], expected slot[3:0], expected full}
  localparam logic [6:0] ALLOC_VEC [12] = '{
    {2'd2, 4'd0, 1'b0}, {2'd2, 4'd1, 1'b0}, {2'd2, 4'd2, 1'b0}, {2'd2, 4'd3, 1'b0},
    {2'd2, 4'd4, 1'b0}, {2'd2, 4'd5, 1'b0}, {2'd2, 4'd6, 1'b0}, {2'd2, 4'd7, 1'b0},
    {2'd2, 4'd8, 1'b0}, {2'd2, 4'd9, 1'b0}, {2'd2, 4'd0, 1'b1}, {2'd0, 4'd0, 1'b0}
  };

  always #5 clk = ~clk;

  wave_issue_sched u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_simd(alloc_simd), .alloc_pc(alloc_pc),
    .alloc_slot(alloc_slot), .alloc_full(alloc_full),
    .free_req(free_req), .free_simd(free_simd), .free_slot(free_slot),
    .stall_req(stall_req), .stall_simd(stall_simd), .stall_slot(stall_slot),
    .wake_req(wake_req), .wake_simd(wake_simd), .wake_slot(wake_slot),
    .issue_valid(issue_valid), .issue_simd(issue_simd), .issue_slot(issue_slot),
    .issue_pc(issue_pc), .lane_active(lane_active), .lane_group(lane_group)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    cyc++;
  endtask

  task automatic wait_turn(input int s);
    do step(); while (((cyc - 1) % 4) != s);
  endtask

  task automatic wait_before(input int s);
    while ((cyc % 4) != s) step();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    alloc_req = 1'b0; free_req = 1'b0; stall_req = 1'b0; wake_req = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    cyc = 0;
  endtask

  task automatic alloc_one(input logic [1:0] s, input logic [47:0] p);
    alloc_req = 1'b1; alloc_simd = s; alloc_pc = p;
    step();
    alloc_req = 1'b0;
  endtask

  task automatic expect_issue(input string req, input logic [3:0] slot, input logic [47:0] p);
    chk({req, " issue_valid"}, 64'(issue_valid), 64'd1);
    chk({req, " issue_simd"}, 64'(issue_simd), 64'd1);
    chk({req, " issue_slot"}, 64'(issue_slot), 64'(slot));
    chk({req, " issue_pc"}, 64'(issue_pc), 64'(p));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // Vector table: allocation order and full flag
    do_reset();
    foreach (ALLOC_VEC[i]) begin
      alloc_req = 1'b1; alloc_simd = ALLOC_VEC[i][6:5]; alloc_pc = 48'(i * 16);
      #1;
      chk("R4 alloc_full", 64'(alloc_full), 64'(ALLOC_VEC[i][0]));
      if (!ALLOC_VEC[i][0]) chk("R4 alloc_slot", 64'(alloc_slot), 64'(ALLOC_VEC[i][4:1]));
      step();
      alloc_req = 1'b0;
    end
    alloc_req = 1'b1; alloc_simd = 2'd2;
    #1;
    chk("R4 rejected alloc left SIMD full", 64'(alloc_full), 64'd1);
    alloc_req = 1'b0;
    free_req = 1'b1; free_simd = 2'd2; free_slot = 4'd7;
    step();
    free_req = 1'b0;
    alloc_req = 1'b1; alloc_simd = 2'd2;
    #1;
    chk("R8 freed slot reused full", 64'(alloc_full), 64'd0);
    chk("R8 freed slot reused slot", 64'(alloc_slot), 64'd7);
    step();
    alloc_req = 1'b0;

    // R1 reset state
    do_reset();
    chk("R1 issue_valid", 64'(issue_valid), 64'd0);
    chk("R1 lane_active", 64'(lane_active), 64'd0);
    alloc_req = 1'b1; alloc_simd = 2'd3;
    #1;
    chk("R1 first alloc slot", 64'(alloc_slot), 64'd0);
    chk("R1 first alloc full", 64'(alloc_full), 64'd0);
    alloc_req = 1'b0;
    step();                              // edge 1, SIMD 0
    chk("R1 lane_active idle", 64'(lane_active), 64'd0);

    // SIMD 1 gets three wavefronts on edges 2..4
    alloc_one(2'd1, P0);                 // edge 2 serves SIMD 1, nothing valid yet
    chk("R6 empty SIMD issues nothing", 64'(issue_valid), 64'd0);
    alloc_one(2'd1, P1);
    alloc_one(2'd1, P2);

    wait_turn(1);                        // edge 6
    expect_issue("R2 R5 R9 first", 4'd0, P0);
    chk("R3 active g0", 64'(lane_active[1]), 64'd1);
    chk("R3 group 0", 64'(lane_group[3:2]), 64'd0);
    for (int g = 1; g < 4; g++) begin
      step();
      chk("R3 active stream", 64'(lane_active[1]), 64'd1);
      chk("R3 group step", 64'(lane_group[3:2]), 64'(g));
      chk("R2 idle SIMD no issue", 64'(issue_valid), 64'd0);
    end
    chk("R3 other SIMD idle", 64'(lane_active[0]), 64'd0);
    wait_turn(1);                        // edge 10
    expect_issue("R5 second", 4'd1, P1);
    chk("R3 restart group", 64'(lane_group[3:2]), 64'd0);
    wait_turn(1);                        // edge 14
    expect_issue("R5 third", 4'd2, P2);
    wait_turn(1);                        // edge 18
    expect_issue("R5 R9 wrap", 4'd0, P0 + 48'd4);

    // Stall and wake
    stall_req = 1'b1; stall_simd = 2'd1; stall_slot = 4'd1;
    step();
    stall_req = 1'b0;
    wait_turn(1);                        // edge 22
    expect_issue("R6 skip waiting", 4'd2, P2 + 48'd4);
    stall_req = 1'b1; stall_slot = 4'd2;
    step();
    stall_slot = 4'd0;
    step();
    stall_req = 1'b0;
    wait_turn(1);                        // edge 26
    chk("R6 all waiting no issue", 64'(issue_valid), 64'd0);
    chk("R6 all waiting no lanes", 64'(lane_active[1]), 64'd0);
    step();
    chk("R6 lanes stay idle", 64'(lane_active[1]), 64'd0);
    wait_before(1);
    wake_req = 1'b1; wake_simd = 2'd1; wake_slot = 4'd1;
    step();                              // edge 30, SIMD 1 turn
    wake_req = 1'b0;
    chk("R7 same-cycle wake not eligible", 64'(issue_valid), 64'd0);
    wait_turn(1);                        // edge 34
    expect_issue("R7 woken slot", 4'd1, P1 + 48'd4);

    // Stall and wake on one edge: wake wins
    stall_req = 1'b1; stall_simd = 2'd1; stall_slot = 4'd0;
    wake_req  = 1'b1; wake_simd  = 2'd1; wake_slot  = 4'd0;
    step();
    stall_req = 1'b0; wake_req = 1'b0;
    // Free slot 1; slot 2 still waiting, slot 0 ready
    free_req = 1'b1; free_simd = 2'd1; free_slot = 4'd1;
    step();
    free_req = 1'b0;
    wait_turn(1);                        // edge 38
    expect_issue("R7 R8 wake wins, freed skipped", 4'd0, P0 + 48'd8);
    wait_turn(1);                        // edge 42
    expect_issue("R8 only ready slot", 4'd0, P0 + 48'd12);
    alloc_req = 1'b1; alloc_simd = 2'd1;
    #1;
    chk("R8 freed slot lowest free", 64'(alloc_slot), 64'd1);
    alloc_req = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end

endmodule